// File: doc/BRIEF.md
# Output-Stationary 4x4 Multiply-Accumulate Grid

This block is a small compute grid for neural-network inference. Sixteen processing elements sit in four rows and four columns. Each element keeps its own 18-bit running sum in place, so that sum never leaves the element while a dot product is being built up. An operand bank feeds the grid. It holds four activations, one for each row, and four weights, one for each column. All values are 9-bit signed numbers.

A host drives the grid one command per cycle. The commands are:

- seed an element's sum with a bias;
- load one operand slot;
- run one broadcast multiply-accumulate step over all sixteen elements;
- clamp every negative sum to zero in place;
- read one element back, either as the raw 18-bit sum or as a 9-bit value requantized with saturation and rounding.

Reads return their data on the cycle after the command is accepted.

Top module: `mac_grid_top`

## Requirements
- R1: A synchronous active-high reset clears all sixteen sums and all eight operand slots, and holds `rd_valid` low.
- R2: Operand load (opcode 2) writes slot `cmd_slot` with the 9-bit value `{cmd_data[7:0], 1'b1}`. Slots 0..3 are the activations of rows 0..3, and slots 4..7 are the weights of columns 0..3.
- R3: Bias load (opcode 1) writes `cmd_data[8:0]`, sign-extended to 18 bits, into element `cmd_elem` and leaves every other element unchanged. Element index e selects row e[3:2] and column e[1:0].
- R4: Multiply-accumulate (opcode 3) adds the signed product activation[row] x weight[col] into every element in the same cycle. The sum wraps modulo 2^18.
- R5: Rectify (opcode 4) sets every element whose sum is negative (bit 17 set) to zero, and leaves non-negative sums unchanged.
- R6: Raw read (opcode 6) returns the 18-bit sum of element `cmd_elem` on `rd_data`, with `rd_valid` high, exactly one cycle after the command.
- R7: Requantized read (opcode 5) returns 9'h1FF in `rd_data[8:0]`, with zeros above it, when bit 17 of the sum is set. Its latency is the same as the raw read.
- R8: When bit 17 is clear, the requantized read returns sum bits 17..9 plus sum bit 8, with zeros above bit 8.
- R9: A cycle with `cmd_valid` low, or with opcode 0 or 7, changes no sum and no operand, and gives no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Opcode |
| cmd_slot | input | 3 | Operand slot index |
| cmd_elem | input | 4 | Element index (row, column) |
| cmd_data | input | 18 | Bias or operand data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 18 | Read data |

## Verification
The multiply-accumulate step is tried with several operand patterns:

- Small positive operands show that the forced low bit 1 is applied and that each row and column is wired to the right slot.
- Mixed-sign operands show that the multiply is signed.
- Repeated products of -255 x -255 and 255 x 255 push sums past bit 17. This tells a correct modulo-2^18 wrap apart from saturation or a wider sum.

Negative biases read back before and after the rectify step tell the sign-extended bias path apart from the clamp. Requantized reads are taken at sums whose bit 8 is set and clear, and at sums with bit 17 set, so that rounding and saturation are each observed separately.

// File: rtl/mac_grid_pkg.sv
package mac_grid_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_BIAS  = 3'd1,
    OP_OPND  = 3'd2,
    OP_MAC   = 3'd3,
    OP_RELU  = 3'd4,
    OP_RDQ   = 3'd5,
    OP_RDRAW = 3'd6
  } grid_op_e;
endpackage

// File: rtl/mac_opnd_buf.sv
module mac_opnd_buf #(
  parameter int OPW   = 9,
  parameter int NSLOT = 8,
  localparam int SW   = $clog2(NSLOT)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [SW-1:0]              waddr,
  input  logic [OPW-2:0]             wdata,
  output logic [NSLOT-1:0][OPW-1:0]  slots
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slots <= '0;
    end else if (we) begin
      slots[waddr] <= {wdata, 1'b1};
    end
  end

  // R2
  opnd_encode_chk: assert property (@(posedge clk) disable iff (rst)
    we |=> slots[$past(waddr)] == {$past(wdata), 1'b1});

  // R9
  opnd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(slots));
endmodule

// File: rtl/mac_pe.sv
module mac_pe #(
  parameter int OPW  = 9,
  parameter int ACCW = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bias_we,
  input  logic [ACCW-1:0] bias_val,
  input  logic            mac_en,
  input  logic            relu_en,
  input  logic [OPW-1:0]  act,
  input  logic [OPW-1:0]  wgt,
  output logic [ACCW-1:0] acc
);
  localparam int PW = 2 * OPW;

  logic signed [PW-1:0] prod;
  logic [ACCW-1:0]      prod_ext;

  assign prod     = $signed(act) * $signed(wgt);
  assign prod_ext = ACCW'(prod);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (bias_we) begin
      acc <= bias_val;
    end else if (mac_en) begin
      acc <= acc + prod_ext;
    end else if (relu_en && acc[ACCW-1]) begin
      acc <= '0;
    end
  end

  // R5
  relu_nonneg_chk: assert property (@(posedge clk) disable iff (rst)
    (relu_en && !bias_we && !mac_en) |=> !acc[ACCW-1]);

  // R5
  relu_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (relu_en && !bias_we && !mac_en && !acc[ACCW-1]) |=> $stable(acc));

  // R4
  mac_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_en && !bias_we) |=> acc == $past(acc) + $past(prod_ext));

  // R9
  pe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !(bias_we || mac_en || relu_en) |=> $stable(acc));
endmodule

// File: rtl/mac_requant.sv
module mac_requant #(
  parameter int OPW  = 9,
  parameter int ACCW = 18
) (
  input  logic [ACCW-1:0] acc,
  output logic [OPW-1:0]  q
);
  localparam int LO = ACCW - OPW;

  always_comb begin
    if (acc[ACCW-1]) begin
      q = '1;
    end else begin
      q = acc[ACCW-1:LO] + OPW'(acc[LO-1]);
    end
  end
endmodule

// File: rtl/mac_grid_top.sv
module mac_grid_top #(
  parameter int N_ROW  = 4,
  parameter int N_COL  = 4,
  parameter int OPW    = 9,
  parameter int ACCW   = 18,
  localparam int NSLOT  = N_ROW + N_COL,
  localparam int NELEM  = N_ROW * N_COL,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int ELEM_W = $clog2(NELEM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [SLOT_W-1:0] cmd_slot,
  input  logic [ELEM_W-1:0] cmd_elem,
  input  logic [ACCW-1:0]   cmd_data,
  output logic              rd_valid,
  output logic [ACCW-1:0]   rd_data
);
  import mac_grid_pkg::*;

  logic is_bias, is_opnd, is_mac, is_relu, is_rdq, is_raw, is_read;
  logic [NSLOT-1:0][OPW-1:0] slots;
  logic [NELEM-1:0][ACCW-1:0] sums;
  logic [ACCW-1:0] bias_ext;
  logic [ACCW-1:0] sel_sum;
  logic [OPW-1:0]  sel_q;
  logic            unused_hi;

  assign is_bias = cmd_valid && (cmd_op == OP_BIAS);
  assign is_opnd = cmd_valid && (cmd_op == OP_OPND);
  assign is_mac  = cmd_valid && (cmd_op == OP_MAC);
  assign is_relu = cmd_valid && (cmd_op == OP_RELU);
  assign is_rdq  = cmd_valid && (cmd_op == OP_RDQ);
  assign is_raw  = cmd_valid && (cmd_op == OP_RDRAW);
  assign is_read = is_rdq || is_raw;

  assign bias_ext  = ACCW'($signed(cmd_data[OPW-1:0]));
  assign unused_hi = ^cmd_data[ACCW-1:OPW];

  mac_opnd_buf #(.OPW(OPW), .NSLOT(NSLOT)) u_opnd (
    .clk   (clk),
    .rst   (rst),
    .we    (is_opnd),
    .waddr (cmd_slot),
    .wdata (cmd_data[OPW-2:0]),
    .slots (slots)
  );

  for (genvar r = 0; r < N_ROW; r++) begin : g_row
    for (genvar c = 0; c < N_COL; c++) begin : g_col
      localparam int IDX = r * N_COL + c;
      mac_pe #(.OPW(OPW), .ACCW(ACCW)) u_pe (
        .clk      (clk),
        .rst      (rst),
        .bias_we  (is_bias && (cmd_elem == ELEM_W'(IDX))),
        .bias_val (bias_ext),
        .mac_en   (is_mac),
        .relu_en  (is_relu),
        .act      (slots[r]),
        .wgt      (slots[N_ROW + c]),
        .acc      (sums[IDX])
      );
    end
  end

  assign sel_sum = sums[cmd_elem];

  mac_requant #(.OPW(OPW), .ACCW(ACCW)) u_rq (
    .acc (sel_sum),
    .q   (sel_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= is_read;
      if (is_raw) begin
        rd_data <= sel_sum;
      end else if (is_rdq) begin
        rd_data <= ACCW'(sel_q);
      end
    end
  end

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    is_read |=> rd_valid);

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !is_read |=> !rd_valid);

  // R7
  rd_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (is_rdq && sel_sum[ACCW-1]) |=> rd_data == ACCW'({OPW{1'b1}}));

  // R8
  rd_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    is_rdq |=> rd_data[ACCW-1:OPW] == '0);

  // R1
  always_ff @(posedge clk) begin
    rst_clear_chk: assert (!$past(rst) || !rd_valid);
  end
endmodule

// File: tb/tb_mac_grid_top.sv
module tb_mac_grid_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = 3'd0;
  logic [2:0]  cmd_slot = 3'd0;
  logic [3:0]  cmd_elem = 4'd0;
  logic [17:0] cmd_data = 18'd0;
  logic        rd_valid;
  logic [17:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [17:0] m_acc [16];
  logic [8:0]  m_op  [8];
  logic [17:0] exp_q [$];
  string       tag_q [$];

  always #10 clk = ~clk;

  mac_grid_top dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_slot(cmd_slot), .cmd_elem(cmd_elem), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [17:0] requant(input logic [17:0] v);
    if (v[17]) return 18'h001FF;
    return 18'(v[17:9]) + 18'(v[8]);
  endfunction

  task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %05h expected %05h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_acc[i] = '0;
    for (int i = 0; i < 8; i++) m_op[i] = '0;
  endtask

  task automatic send(input logic [2:0] op, input logic [2:0] slot,
                      input logic [3:0] elem, input logic [17:0] data, input string tag);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_slot = slot; cmd_elem = elem; cmd_data = data;
    case (op)
      3'd1: m_acc[elem] = 18'($signed(data[8:0]));
      3'd2: m_op[slot] = {data[7:0], 1'b1};
      3'd3: for (int r = 0; r < 4; r++)
              for (int c = 0; c < 4; c++) begin
                logic signed [17:0] p;
                p = $signed(m_op[r]) * $signed(m_op[4 + c]);
                m_acc[r*4 + c] = m_acc[r*4 + c] + p;
              end
      3'd4: for (int i = 0; i < 16; i++) if (m_acc[i][17]) m_acc[i] = '0;
      3'd5: begin exp_q.push_back(requant(m_acc[elem])); tag_q.push_back(tag); end
      3'd6: begin exp_q.push_back(m_acc[elem]); tag_q.push_back(tag); end
      default: ;
    endcase
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic read_all(input logic [2:0] op, input string tag);
    for (int e = 0; e < 16; e++) send(op, 3'd0, 4'(e), 18'd0, tag);
  endtask

  // monitor: pops expected read data as the design returns it
  initial begin
    forever begin
      @(negedge clk); #1;
      if (!rst && rd_valid) begin
        if (exp_q.size() == 0) begin
          vectors++; errors++;
          $display("FAIL R9: unexpected rd_valid, got %05h expected none", rd_data);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 rd_valid in reset", 18'(rd_valid), 18'd0);
    @(negedge clk); rst = 1'b0;
    read_all(3'd6, "R1 sums cleared");
    // operands cleared: MAC of zeros keeps sums at zero
    send(3'd3, 0, 0, 0, "R1");
    read_all(3'd6, "R1 operands cleared");

    // R2 small positive operands: a = {d,1}
    for (int s = 0; s < 8; s++) send(3'd2, 3'(s), 0, 18'(s + 1), "R2");
    send(3'd3, 0, 0, 0, "R2");
    read_all(3'd6, "R2 operand encoding and slot mapping");

    // R3 biases, incl. negative sign extension and ignored upper data bits
    send(3'd1, 0, 4'd5, 18'h3FEF0, "R3");
    send(3'd1, 0, 4'd10, 18'h000FF, "R3");
    send(3'd1, 0, 4'd15, 18'h00100, "R3");
    read_all(3'd6, "R3 bias load");

    // R4 mixed signs
    send(3'd2, 3'd0, 0, 18'h80, "R4"); send(3'd2, 3'd1, 0, 18'h7F, "R4");
    send(3'd2, 3'd4, 0, 18'hC3, "R4"); send(3'd2, 3'd6, 0, 18'h11, "R4");
    send(3'd3, 0, 0, 0, "R4");
    send(3'd3, 0, 0, 0, "R4");
    read_all(3'd6, "R4 signed mac");

    // R4 wrap: -255 * -255 repeated and 255*255
    for (int e = 0; e < 16; e++) send(3'd1, 0, 4'(e), 18'd0, "R3");
    for (int s = 0; s < 8; s++) send(3'd2, 3'(s), 0, (s % 2) ? 18'h7F : 18'h80, "R4");
    for (int k = 0; k < 5; k++) send(3'd3, 0, 0, 0, "R4");
    read_all(3'd6, "R4 wrap");
    read_all(3'd5, "R7 R8 requant after wrap");

    // R8 rounding: bit 8 set vs clear
    send(3'd1, 0, 4'd0, 18'h0FF, "R8");
    send(3'd1, 0, 4'd1, 18'h100, "R8");
    for (int s = 0; s < 8; s++) send(3'd2, 3'(s), 0, 18'h00, "R8");
    send(3'd2, 3'd0, 0, 18'h7F, "R8"); send(3'd2, 3'd4, 0, 18'h7F, "R8");
    send(3'd3, 0, 0, 0, "R8");
    read_all(3'd5, "R8 rounding");
    read_all(3'd6, "R8 raw");

    // R7 negative sums saturate, then R5 rectify
    send(3'd1, 0, 4'd3, 18'h1FF, "R7");
    send(3'd1, 0, 4'd7, 18'h100, "R7");
    read_all(3'd5, "R7 saturate");
    send(3'd4, 0, 0, 0, "R5");
    read_all(3'd6, "R5 rectify");

    // R9 idle and undefined opcodes change nothing
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 3'd3; cmd_data = 18'h3FFFF; cmd_slot = 3'd0;
    @(posedge clk); #1;
    send(3'd7, 0, 0, 18'h3FFFF, "R9");
    send(3'd0, 0, 0, 18'h3FFFF, "R9");
    read_all(3'd6, "R9 no effect");
    send(3'd3, 0, 0, 0, "R9");
    read_all(3'd6, "R9 operands kept");

    repeat (4) @(posedge clk);
    #1;
    check("R6 all reads returned", 18'(exp_q.size()), 18'd0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule